// File: doc/BRIEF.md
# Performance Counter Port with Overloaded Selector and Counter Access

This block holds eight event counters and the eight selectors that tell each counter what to count. All of them sit behind a single memory-mapped register address. An upstream decoder raises `req_valid` only when an access hits that register. The block then looks at how the access is shaped to decide what it reaches. A single access, byte or doubleword, reaches the selectors. A burst access reaches the counters.

Each selector is one byte. A selector value of zero turns its counter off. A value `v` from 1 up to the number of event lines makes the counter follow event line `v-1`. Each counter is 64 bits and gains one on every clock cycle in which its chosen event line is high.

Software programs the selectors one byte at a time, or all eight at once as a doubleword. It reads, writes or zeroes the counters with eight-beat bursts. A fill burst clears all eight counters in a single request cycle. Read data comes back one cycle after the request.

Top module: `pmc_port`

## Requirements
- R1: After synchronous reset every selector and every counter reads back as zero, and `rsp_valid` is low.
- R2: A single byte store (`req_burst`=0, `req_size`=0, `req_write`=1) writes `req_wdata[7:0]` into the selector numbered by `req_addr[2:0]`. The other seven selectors keep their values.
- R3: A single byte load returns the selector numbered by `req_addr[2:0]` in `rsp_data[7:0]`, with `rsp_data[63:8]` zero.
- R4: A single doubleword store (`req_size`=1) writes all eight selectors at once, selector i taking `req_wdata[8i+7:8i]`. A doubleword load returns the eight selectors packed in the same byte positions.
- R5: A counter whose selector `v` is nonzero and no greater than `NUM_EVT` gains exactly one in each cycle where `evt_i[v-1]` is high. It wraps from all ones to zero. A selector of 0, or a selector above `NUM_EVT`, never counts.
- R6: A burst load beat (`req_burst`=1, `req_write`=0) with beat index `req_addr[2:0]`=b returns the value counter b held in the request cycle.
- R7: A burst store beat (`req_burst`=1, `req_write`=1, `req_fill`=0) with beat index b writes `req_wdata` into counter b. This write wins over an event increment in the same cycle.
- R8: A fill burst (`req_burst`=1, `req_write`=1, `req_fill`=1) clears all eight counters in one cycle and ignores `req_wdata`. The clear wins over event increments in the same cycle.
- R9: `rsp_valid` is high in exactly the cycle after each accepted load and low after stores and idle cycles.
- R10: Single accesses never change a counter, and burst accesses never change a selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_EVT | Event lines from the resource, one level per cycle |
| req_valid | input | 1 | Access to the counter port register this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 1 | Single-access size: 0 = byte, 1 = doubleword |
| req_burst | input | 1 | 1 = one beat of an eight-beat burst |
| req_fill | input | 1 | With a burst store: clear all counters |
| req_addr | input | 3 | Byte selector number, or burst beat index |
| req_wdata | input | 64 | Store data |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | 64 | Load data |

## Verification
The assertions assume the requests follow the port's encoding. `req_fill` only matters on a burst store, and burst beats carry their counter number in `req_addr`. Every request field is held for exactly one cycle. The stimulus drives one request per cycle and changes event lines and requests only on falling edges. This is so the write-over-increment cases land in the same rising edge as an event on purpose. Counter contents are observed only through burst loads, and selector contents only through single loads. Each ignored-effect check therefore reads back through the bus.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int PMC_NUM_CTR = 8;
    localparam int PMC_SEL_W   = 8;
    localparam int PMC_CTR_W   = 64;
    localparam int PMC_DATA_W  = PMC_NUM_CTR * PMC_SEL_W;
    localparam int PMC_IDX_W   = $clog2(PMC_NUM_CTR);

    typedef struct packed {
        logic sel_one_we;
        logic sel_all_we;
        logic ctr_we;
        logic ctr_clr;
        logic rd_sel_one;
        logic rd_sel_all;
        logic rd_ctr;
    } pmc_op_t;

    function automatic logic is_load(input pmc_op_t op);
        return op.rd_sel_one | op.rd_sel_all | op.rd_ctr;
    endfunction
endpackage

// File: rtl/pmc_decode.sv
module pmc_decode
    import pmc_pkg::*;
(
    input  logic    valid_i,
    input  logic    write_i,
    input  logic    size_i,
    input  logic    burst_i,
    input  logic    fill_i,
    output pmc_op_t op_o
);
    logic single;
    logic multi;

    always_comb begin
        single          = valid_i & ~burst_i;
        multi           = valid_i &  burst_i;
        op_o            = '0;
        op_o.sel_one_we = single &  write_i & ~size_i;
        op_o.sel_all_we = single &  write_i &  size_i;
        op_o.rd_sel_one = single & ~write_i & ~size_i;
        op_o.rd_sel_all = single & ~write_i &  size_i;
        op_o.ctr_we     = multi  &  write_i & ~fill_i;
        op_o.ctr_clr    = multi  &  write_i &  fill_i;
        op_o.rd_ctr     = multi  & ~write_i;
    end

    always_comb begin
        assert ($onehot0(op_o)); // R10: an access reaches one storage kind only
    end
endmodule

// File: rtl/pmc_selbank.sv
module pmc_selbank #(
    parameter int NUM_CTR = pmc_pkg::PMC_NUM_CTR,
    parameter int SEL_W   = pmc_pkg::PMC_SEL_W,
    localparam int IDX_W  = $clog2(NUM_CTR),
    localparam int VEC_W  = NUM_CTR * SEL_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           one_we_i,
    input  logic                           all_we_i,
    input  logic [IDX_W-1:0]               idx_i,
    input  logic [VEC_W-1:0]               wdata_i,
    output logic [NUM_CTR-1:0][SEL_W-1:0]  sel_o
);
    logic [NUM_CTR-1:0][SEL_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (all_we_i) begin
            sel_q <= wdata_i;
        end else if (one_we_i) begin
            sel_q[idx_i] <= wdata_i[SEL_W-1:0];
        end
    end

    assign sel_o = sel_q;

    p_byte_store_r2: assert property (@(posedge clk) disable iff (rst)
        (one_we_i && !all_we_i) |=> sel_q[$past(idx_i)] == $past(wdata_i[SEL_W-1:0]));

    p_dword_store_r4: assert property (@(posedge clk) disable iff (rst)
        all_we_i |=> sel_q == $past(wdata_i));

    p_idle_keeps_sel_r10: assert property (@(posedge clk) disable iff (rst)
        (!one_we_i && !all_we_i) |=> $stable(sel_q));
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
    parameter int CTR_W   = pmc_pkg::PMC_CTR_W,
    parameter int SEL_W   = pmc_pkg::PMC_SEL_W,
    parameter int NUM_EVT = 32,
    localparam int EIDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               we_i,
    input  logic               clr_i,
    input  logic [CTR_W-1:0]   wdata_i,
    output logic [CTR_W-1:0]   cnt_o
);
    logic [CTR_W-1:0] cnt_q;
    logic [SEL_W-1:0] ev_num;
    logic             in_range;
    logic             hit;

    always_comb begin
        ev_num   = sel_i - SEL_W'(1);
        in_range = (sel_i != '0) && (32'(sel_i) <= NUM_EVT);
        hit      = in_range && evt_i[ev_num[EIDX_W-1:0]];
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (we_i) begin
            cnt_q <= wdata_i;
        end else if (hit) begin
            cnt_q <= cnt_q + CTR_W'(1);
        end
    end

    assign cnt_o = cnt_q;

    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!we_i && !clr_i && in_range && evt_i[ev_num[EIDX_W-1:0]])
        |=> cnt_q == CTR_W'($past(cnt_q) + CTR_W'(1)));

    p_disabled_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!we_i && !clr_i && sel_i == '0) |=> $stable(cnt_q));

    p_write_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (we_i && !clr_i) |=> cnt_q == $past(wdata_i));

    p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> cnt_q == '0);
endmodule

// File: rtl/pmc_port.sv
module pmc_port
    import pmc_pkg::*;
#(
    parameter int NUM_EVT = 32,
    localparam int DATA_W = PMC_DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_size,
    input  logic               req_burst,
    input  logic               req_fill,
    input  logic [2:0]         req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data
);
    pmc_op_t                                  op;
    logic [PMC_NUM_CTR-1:0][PMC_SEL_W-1:0]   sel;
    logic [PMC_CTR_W-1:0]                    cnt [PMC_NUM_CTR];
    logic [PMC_IDX_W-1:0]                    idx;
    logic [DATA_W-1:0]                       rd_next;

    assign idx = req_addr[PMC_IDX_W-1:0];

    pmc_decode u_dec (
        .valid_i (req_valid),
        .write_i (req_write),
        .size_i  (req_size),
        .burst_i (req_burst),
        .fill_i  (req_fill),
        .op_o    (op)
    );

    pmc_selbank #(
        .NUM_CTR (PMC_NUM_CTR),
        .SEL_W   (PMC_SEL_W)
    ) u_sel (
        .clk      (clk),
        .rst      (rst),
        .one_we_i (op.sel_one_we),
        .all_we_i (op.sel_all_we),
        .idx_i    (idx),
        .wdata_i  (req_wdata),
        .sel_o    (sel)
    );

    for (genvar g = 0; g < PMC_NUM_CTR; g++) begin : g_ctr
        logic hit_we;
        assign hit_we = op.ctr_we && (idx == PMC_IDX_W'(g));

        pmc_counter #(
            .CTR_W   (PMC_CTR_W),
            .SEL_W   (PMC_SEL_W),
            .NUM_EVT (NUM_EVT)
        ) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .sel_i   (sel[g]),
            .evt_i   (evt_i),
            .we_i    (hit_we),
            .clr_i   (op.ctr_clr),
            .wdata_i (req_wdata),
            .cnt_o   (cnt[g])
        );
    end

    always_comb begin
        rd_next = '0;
        if (op.rd_sel_one) begin
            rd_next = DATA_W'(sel[idx]);
        end else if (op.rd_sel_all) begin
            rd_next = sel;
        end else if (op.rd_ctr) begin
            rd_next = cnt[idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= is_load(op);
            if (is_load(op)) begin
                rsp_data <= rd_next;
            end
        end
    end

    p_rsp_after_load_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    p_no_rsp_otherwise_r9: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);

    p_byte_load_zero_ext_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !req_burst && !req_size)
        |=> rsp_data[DATA_W-1:PMC_SEL_W] == '0);

    p_burst_keeps_sel_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_burst) |=> $stable(sel));
endmodule

// File: tb/sim_pmc_port.sv
module sim_pmc_port;
    localparam int NEVT = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic [NEVT-1:0] evt_i;
    logic            req_valid, req_write, req_size, req_burst, req_fill;
    logic [2:0]      req_addr;
    logic [63:0]     req_wdata;
    logic            rsp_valid;
    logic [63:0]     rsp_data;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    pmc_port #(.NUM_EVT(NEVT)) u0 (
        .clk(clk), .rst(rst), .evt_i(evt_i),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_burst(req_burst), .req_fill(req_fill), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge with response sampled.
    task automatic access(input logic wr, input logic sz, input logic bu, input logic fi,
                          input logic [2:0] a, input logic [63:0] d,
                          output logic [63:0] r, output logic rv);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_burst = bu;
        req_fill = fi; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_size = 1'b0; req_burst = 1'b0;
        req_fill = 1'b0; req_addr = '0; req_wdata = '0;
        r = rsp_data; rv = rsp_valid;
    endtask

    task automatic rd_ctr(input logic [2:0] i, output logic [63:0] v);
        logic rv;
        access(1'b0, 1'b0, 1'b1, 1'b0, i, 64'd0, v, rv);
    endtask

    task automatic rd_sels(output logic [63:0] v);
        logic rv;
        access(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 64'd0, v, rv);
    endtask

    task automatic t_reset;
        logic [63:0] v;
        check("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        rd_sels(v);
        check("R1 selectors after reset", v, 64'd0);
        for (int i = 0; i < 8; i++) begin
            rd_ctr(3'(i), v);
            check("R1 counter after reset", v, 64'd0);
        end
    endtask

    task automatic t_byte_sel;
        logic [63:0] v; logic rv;
        access(1'b1, 1'b0, 1'b0, 1'b0, 3'd5, 64'hFFFF_FFFF_FFFF_FFA7, v, rv);
        check("R9 no response after store", {63'd0, rv}, 64'd0);
        access(1'b1, 1'b0, 1'b0, 1'b0, 3'd2, 64'h0000_0000_0000_0033, v, rv);
        access(1'b0, 1'b0, 1'b0, 1'b0, 3'd5, 64'd0, v, rv);
        check("R9 response after load", {63'd0, rv}, 64'd1);
        check("R3 byte load sel5", v, 64'h0000_0000_0000_00A7);
        access(1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 64'd0, v, rv);
        check("R3 byte load sel2", v, 64'h33);
        rd_sels(v);
        check("R2 only addressed selectors written", v, 64'h0000_A700_0033_0000);
    endtask

    task automatic t_dword_sel;
        logic [63:0] v; logic rv;
        // sel0=1(evt0) sel1=2(evt1) sel2=0 sel3=40(out of range) sel4=32(evt31)
        access(1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 64'h0000_0020_2800_0201, v, rv);
        rd_sels(v);
        check("R4 dword store/load", v, 64'h0000_0020_2800_0201);
        access(1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 64'd0, v, rv);
        check("R4 byte 4 of dword", v, 64'h20);
    endtask

    task automatic t_count;
        logic [63:0] v;
        evt_i = 32'hFFFF_FFFF;
        repeat (5) @(negedge clk);
        evt_i = 32'h0000_0002;
        repeat (3) @(negedge clk);
        evt_i = '0;
        rd_ctr(3'd0, v); check("R5 counter0 counts evt0", v, 64'd5);
        rd_ctr(3'd1, v); check("R5 counter1 counts evt1", v, 64'd8);
        rd_ctr(3'd2, v); check("R5 selector 0 disables", v, 64'd0);
        rd_ctr(3'd3, v); check("R5 selector above range never counts", v, 64'd0);
        rd_ctr(3'd4, v); check("R5 counter4 counts top event", v, 64'd5);
        rd_ctr(3'd7, v); check("R5 counter7 disabled", v, 64'd0);
    endtask

    task automatic t_burst_rw;
        logic [63:0] v; logic rv;
        access(1'b1, 1'b0, 1'b1, 1'b0, 3'd6, 64'hDEAD_BEEF_0123_4567, v, rv);
        rd_ctr(3'd6, v);
        check("R6 burst load returns counter6", v, 64'hDEAD_BEEF_0123_4567);
        rd_ctr(3'd5, v);
        check("R7 burst store touches only its beat", v, 64'd0);
        rd_sels(v);
        check("R10 burst leaves selectors", v, 64'h0000_0020_2800_0201);
        access(1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 64'h0000_0020_2800_0201, v, rv);
        rd_ctr(3'd6, v);
        check("R10 single store leaves counters", v, 64'hDEAD_BEEF_0123_4567);
        // wrap: counter0 all ones, one event -> zero
        access(1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, v, rv);
        evt_i = 32'h1;
        @(negedge clk);
        evt_i = '0;
        rd_ctr(3'd0, v);
        check("R5 counter wraps to zero", v, 64'd0);
    endtask

    task automatic t_priority;
        logic [63:0] v; logic rv;
        evt_i = 32'h1;
        access(1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 64'h0000_0000_0000_1234, v, rv);
        evt_i = '0;
        rd_ctr(3'd0, v);
        check("R7 write wins over increment", v, 64'h1234);
        evt_i = 32'h1;
        rd_ctr(3'd0, v);
        evt_i = '0;
        check("R6 load returns pre-increment value", v, 64'h1234);
        rd_ctr(3'd0, v);
        check("R5 increment during load", v, 64'h1235);
    endtask

    task automatic t_fill;
        logic [63:0] v; logic rv;
        evt_i = 32'hFFFF_FFFF;
        access(1'b1, 1'b0, 1'b1, 1'b1, 3'd3, 64'hFFFF_0000_FFFF_0000, v, rv);
        evt_i = '0;
        for (int i = 0; i < 8; i++) begin
            rd_ctr(3'(i), v);
            check("R8 fill clears counter", v, 64'd0);
        end
        evt_i = 32'h2;
        repeat (2) @(negedge clk);
        evt_i = '0;
        rd_ctr(3'd1, v);
        check("R8 counting resumes after fill", v, 64'd2);
    endtask

    initial begin
        rst = 1'b1; evt_i = '0;
        req_valid = 1'b0; req_write = 1'b0; req_size = 1'b0; req_burst = 1'b0;
        req_fill = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_byte_sel();
        t_dword_sel();
        t_count();
        t_burst_rw();
        t_priority();
        t_fill();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule